// File: doc/BRIEF.md
# Symmetric ROM-Coefficient FIR Filter

This block is a finite impulse response filter for a stream of signed samples from an analogue-to-digital converter. Each accepted sample enters a tap-delay line. Every output is the sum, over all taps, of a past sample times a fixed 18-bit signed coefficient. The coefficients are constants computed when the design is elaborated, so they sit in read-only storage and cannot be changed at run time.

The coefficient set has even length and linear phase, so it is mirror-symmetric. Its two middle entries are equal. A single unit sample at the input therefore brings the coefficients out in order. The peak value appears on two outputs in a row, and the first half then comes back in reverse order. A unit step settles to the sum of all coefficients.

Because of the symmetry, the design can add the two samples that share a coefficient before multiplying. This halves the number of multipliers. A parameter selects between this folded form and a plain form with one multiplier per tap. The products feed a fully registered binary adder tree. The output valid is the input valid delayed by the pipeline depth.

Top module: `fir_sym_rom`

## Requirements
- R1: Output n (counting accepted samples from reset, starting at 0) equals the sum over k = 0 to TAPS-1 of c[k]·x[n-k], where x[j] is the j-th accepted signed sample and x[j] = 0 for j < 0. Exactly one output is produced per accepted sample.
- R2: The coefficients are symmetric, with c[k] = c[TAPS-1-k]. Let m = min(k, TAPS-1-k). For COEF_SET = 0, c[k] = ((97·m² + 13·m + 5) mod 262144) − 131072. For COEF_SET = 1, c[k] is 1, 2, 3 for m = 0, 1, 2, and 5 for any larger m.
- R3: out_data is ACC_W = DATA_W + 18 + clog2(TAPS) bits wide and signed. It is exact for all inputs, including full-scale samples whose signs match every coefficient, or oppose every coefficient.
- R4: A single input of value 1 followed by zeros yields c[0], c[1], ... in order. The middle value c[TAPS/2-1] appears on two consecutive outputs, and the following outputs repeat the first half in reverse order.
- R5: A constant input of 1 settles, from output TAPS-1 onward, to the sum of all coefficients. With TAPS = 8 and COEF_SET = 1 this value is 22.
- R6: out_valid equals in_valid delayed by LATENCY = clog2(L) + 2 clock cycles. L is TAPS/2 when FOLD = 1 and TAPS when FOLD = 0.
- R7: The delay line advances only in cycles with in_valid high. Idle cycles between samples do not change the output sequence, and out_data holds its value while out_valid is low.
- R8: While rst_n is low at a rising clock edge, the delay line and the pipeline are cleared. After reset, out_valid is 0 and out_data is 0, and the outputs that follow match a filter started from rest.
- R9: The folded form (FOLD = 1) and the plain form (FOLD = 0) give identical output values for the same input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_sample; the delay line shifts when it is high |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Marks a filter output, LATENCY cycles after in_valid |
| out_data | output | ACC_W | Signed sum of products |

## Verification
The bench builds three copies of the filter. The first uses the defaults: 16-bit samples, 384 taps, COEF_SET 0, folded. This copy gives the full impulse mirror around the repeated middle coefficient, the settled step sum and the full-scale accumulator extremes at real size. The other two use 8 taps and COEF_SET 1, one folded and one plain. With these small copies the step value of 22 and the whole impulse can be seen within a few cycles. They also allow the two multiplier forms and their different latencies (4 and 5 cycles, against 10 for the default copy) to be compared on the same input stream.

// File: rtl/fir_sym_pkg.sv
// Package: constants and elaboration-time helpers shared by the FIR filter.
// Assumes the coefficient index lies in 0..taps-1 and taps is even.
package fir_sym_pkg;

    localparam int COEF_W = 18;

    // Distance of a tap from the nearer end of the coefficient set.
    function automatic int fold_index(input int taps, input int idx);
        return (idx < taps / 2) ? idx : taps - 1 - idx;
    endfunction

    // Coefficient value for a tap; symmetric by construction of fold_index.
    function automatic logic signed [COEF_W-1:0] coef_value(input int set_sel,
                                                           input int taps,
                                                           input int idx);
        int m;
        int raw;
        m = fold_index(taps, idx);
        if (set_sel == 1) begin
            raw = (m < 3) ? m + 1 : 5;
        end else begin
            raw = ((m * m * 97 + m * 13 + 5) % 262144) - 131072;
        end
        return COEF_W'(raw);
    endfunction

endpackage

// File: rtl/fir_tap_line.sv
// Tap-delay line: tap[0] holds the newest accepted sample, tap[TAPS-1] the oldest.
// Assumes shift_en marks an accepted sample; the line is frozen otherwise.
module fir_tap_line #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] tap [TAPS]
);

    // Clear on reset; shift one position per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) begin
                tap[i] <= '0;
            end
        end else if (shift_en) begin
            tap[0] <= din;
            for (int i = 1; i < TAPS; i++) begin
                tap[i] <= tap[i-1];
            end
        end
    end

endmodule

// File: rtl/fir_mult_bank.sv
// Multiplier bank: one registered product per lane, coefficients from
// elaboration-time constants. FOLD != 0 pre-adds mirrored taps so that
// TAPS/2 lanes suffice; FOLD == 0 uses one lane per tap.
// Assumes TAPS is even when FOLD is set.
module fir_mult_bank
    import fir_sym_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TAPS     = 384,
    parameter int COEF_SET = 0,
    parameter int FOLD     = 1,
    localparam int LANES   = (FOLD != 0) ? TAPS / 2 : TAPS,
    localparam int PRE_W   = DATA_W + 1,
    localparam int PROD_W  = PRE_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] tap  [TAPS],
    output logic signed [PROD_W-1:0] prod [LANES]
);

    logic signed [PRE_W-1:0] pre [LANES];

    if (FOLD != 0) begin : g_fold
        // Pre-add the two taps that share one coefficient.
        always_comb begin
            for (int j = 0; j < LANES; j++) begin
                pre[j] = PRE_W'(tap[j]) + PRE_W'(tap[TAPS-1-j]);
            end
        end
    end else begin : g_flat
        // Pass each tap straight to its own lane, sign-extended.
        always_comb begin
            for (int j = 0; j < LANES; j++) begin
                pre[j] = PRE_W'(tap[j]);
            end
        end
    end

    // Register the product of each lane with its constant coefficient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < LANES; j++) begin
                prod[j] <= '0;
            end
        end else begin
            for (int j = 0; j < LANES; j++) begin
                prod[j] <= PROD_W'(pre[j]) * PROD_W'(coef_value(COEF_SET, TAPS, j));
            end
        end
    end

endmodule

// File: rtl/fir_adder_tree.sv
// Pipelined binary adder tree: LEAVES inputs padded with zeros to a power of
// two, one register per level, so the sum appears clog2(LEAVES) cycles later.
// Assumes LEAVES >= 2 and OUT_W wide enough for the full sum.
module fir_adder_tree #(
    parameter int LEAVES = 192,
    parameter int IN_W   = 35,
    parameter int OUT_W  = 43,
    localparam int LEVELS = $clog2(LEAVES),
    localparam int PADDED = 1 << LEVELS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  leaf_in [LEAVES],
    output logic signed [OUT_W-1:0] sum_out
);

    // Leaf stage: sign-extend real inputs, zero the padding.
    for (genvar i = 0; i < PADDED; i++) begin : g_leaf
        logic signed [OUT_W-1:0] v;
        if (i < LEAVES) begin : g_used
            assign v = OUT_W'(leaf_in[i]);
        end else begin : g_pad
            assign v = '0;
        end
    end

    // Heap-numbered nodes: node i adds children 2i and 2i+1.
    for (genvar i = 1; i < PADDED; i++) begin : g_node
        logic signed [OUT_W-1:0] q;
        logic signed [OUT_W-1:0] a;
        logic signed [OUT_W-1:0] b;
        if (2 * i >= PADDED) begin : g_bottom
            assign a = g_leaf[2*i-PADDED].v;
            assign b = g_leaf[2*i+1-PADDED].v;
        end else begin : g_inner
            assign a = g_node[2*i].q;
            assign b = g_node[2*i+1].q;
        end
        // Register the partial sum of this node.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= a + b;
            end
        end
    end

    assign sum_out = g_node[1].q;

endmodule

// File: rtl/fir_sym_rom.sv
// Top: FIR filter with a symmetric constant coefficient set.
// Chain: tap line (shifts on in_valid) -> multiplier bank (1 register) ->
// adder tree (clog2(lanes) registers). The valid flag is delayed to match.
// Assumes a signed input stream; no back-pressure; FOLD needs an even TAPS.
module fir_sym_rom
    import fir_sym_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TAPS     = 384,
    parameter int COEF_SET = 0,
    parameter int FOLD     = 1,
    localparam int ACC_W   = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_data
);

    localparam int LANES   = (FOLD != 0) ? TAPS / 2 : TAPS;
    localparam int PROD_W  = DATA_W + 1 + COEF_W;
    localparam int LATENCY = $clog2(LANES) + 2;

    logic signed [DATA_W-1:0] tap  [TAPS];
    logic signed [PROD_W-1:0] prod [LANES];
    logic [LATENCY-1:0]       vld_pipe;

    fir_tap_line #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS)
    ) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_sample),
        .tap      (tap)
    );

    fir_mult_bank #(
        .DATA_W   (DATA_W),
        .TAPS     (TAPS),
        .COEF_SET (COEF_SET),
        .FOLD     (FOLD)
    ) u_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .tap   (tap),
        .prod  (prod)
    );

    fir_adder_tree #(
        .LEAVES (LANES),
        .IN_W   (PROD_W),
        .OUT_W  (ACC_W)
    ) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .leaf_in (prod),
        .sum_out (out_data)
    );

    // Delay the input valid by the depth of the data path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_pipe <= '0;
        end else begin
            vld_pipe <= {vld_pipe[LATENCY-2:0], in_valid};
        end
    end

    assign out_valid = vld_pipe[LATENCY-1];

endmodule

// File: rtl/fir_sym_rom_chk.sv
// Checker for fir_sym_rom: reset clearing, valid latency, output hold while
// idle. Counts edges since reset so that no property looks across a reset.
module fir_sym_rom_chk #(
    parameter int LAT   = 10,
    parameter int ACC_W = 43
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [ACC_W-1:0] out_data
);

    int unsigned since_rst;

    // Saturating count of clock edges seen with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 0;
        end else if (since_rst < 1000) begin
            since_rst <= since_rst + 1;
        end
    end

    // R8: a reset edge leaves the outputs cleared.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R8: outputs are never unknown once out of reset.
    p_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({out_valid, out_data}));

    // R6: out_valid is in_valid delayed by LAT cycles.
    p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LAT) |-> (out_valid == $past(in_valid, LAT)));

    // R7: no accepted sample means the delay line did not move, so data holds.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LAT + 1 && !out_valid) |-> $stable(out_data));

endmodule

bind fir_sym_rom fir_sym_rom_chk #(
    .LAT   (LATENCY),
    .ACC_W (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/fir_sym_rom_test.sv
// Directed bench: three filter copies on one input stream, each output compared
// with a behavioural convolution over coefficients computed from R2.
module fir_sym_rom_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int BIG_TAPS   = 384;
    localparam int SML_TAPS   = 8;
    localparam int BIG_ACC    = DW + 18 + $clog2(BIG_TAPS);
    localparam int SML_ACC    = DW + 18 + $clog2(SML_TAPS);
    localparam int BIG_LAT    = $clog2(BIG_TAPS / 2) + 2;
    localparam int SML_LAT    = $clog2(SML_TAPS / 2) + 2;
    localparam int FLT_LAT    = $clog2(SML_TAPS) + 2;
    localparam int HIST_N     = 4096;
    localparam int LOG_N      = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;

    logic                      big_ov, sml_ov, flt_ov;
    logic signed [BIG_ACC-1:0] big_od;
    logic signed [SML_ACC-1:0] sml_od;
    logic signed [SML_ACC-1:0] flt_od;

    int checks = 0;
    int errors = 0;
    longint hist [HIST_N];
    int hist_len = 0;
    int n_big = 0;
    int n_sml = 0;
    int n_flt = 0;
    longint big_log [LOG_N];
    longint sml_log [LOG_N];
    longint flt_log [LOG_N];
    string cur_scn = "reset";

    always #(CLK_PERIOD / 2) clk = ~clk;

    fir_sym_rom #(.DATA_W(DW), .TAPS(BIG_TAPS), .COEF_SET(0), .FOLD(1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(big_ov), .out_data(big_od));

    fir_sym_rom #(.DATA_W(DW), .TAPS(SML_TAPS), .COEF_SET(1), .FOLD(1)) uut_small (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(sml_ov), .out_data(sml_od));

    fir_sym_rom #(.DATA_W(DW), .TAPS(SML_TAPS), .COEF_SET(1), .FOLD(0)) uut_flat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(flt_ov), .out_data(flt_od));

    // Coefficient per R2, written from the requirement text.
    function automatic longint coef_tb(input int set_sel, input int taps, input int k);
        int m;
        longint r;
        m = (k >= taps / 2) ? taps - 1 - k : k;
        if (set_sel == 1) begin
            case (m)
                0:       r = 1;
                1:       r = 2;
                2:       r = 3;
                default: r = 5;
            endcase
        end else begin
            r = ((longint'(m) * m * 97 + m * 13 + 5) % 262144) - 131072;
        end
        return r;
    endfunction

    // Reference output n per R1.
    function automatic longint conv(input int set_sel, input int taps, input int n);
        longint s = 0;
        for (int k = 0; k < taps; k++) begin
            if (n - k >= 0) s += coef_tb(set_sel, taps, k) * hist[n-k];
        end
        return s;
    endfunction

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s [%s]: actual %0d expected %0d", req, what, cur_scn, act, exp);
        end
    endtask

    // Output monitor: every valid output against the convolution (R1, R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (big_ov) begin
                check_eq("R1", "big output", longint'(big_od), conv(0, BIG_TAPS, n_big));
                if (n_big < LOG_N) big_log[n_big] = longint'(big_od);
                n_big++;
            end
            if (sml_ov) begin
                check_eq("R1", "small folded output", longint'(sml_od), conv(1, SML_TAPS, n_sml));
                if (n_sml < LOG_N) sml_log[n_sml] = longint'(sml_od);
                n_sml++;
            end
            if (flt_ov) begin
                check_eq("R9", "small plain output", longint'(flt_od), conv(1, SML_TAPS, n_flt));
                if (n_flt < LOG_N) flt_log[n_flt] = longint'(flt_od);
                n_flt++;
            end
        end
    end

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        hist_len = 0;
        n_big = 0;
        n_sml = 0;
        n_flt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input longint v, input bit vld);
        @(negedge clk);
        in_sample = DW'(v);
        in_valid = vld;
        if (vld) begin
            hist[hist_len] = v;
            hist_len++;
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic test_reset();
        cur_scn = "reset";
        apply_reset();
        @(negedge clk);
        check_eq("R8", "big valid after reset", longint'(big_ov), 0);
        check_eq("R8", "big data after reset", longint'(big_od), 0);
        check_eq("R8", "small valid after reset", longint'(sml_ov), 0);
        check_eq("R8", "small data after reset", longint'(sml_od), 0);
    endtask

    task automatic test_impulse();
        cur_scn = "impulse";
        apply_reset();
        push(1, 1'b1);
        for (int i = 0; i < 400; i++) push(0, 1'b1);
        idle(BIG_LAT + 4);
        check_eq("R1", "big output count", n_big, 401);
        check_eq("R4", "first output is c[0]", big_log[0], coef_tb(0, BIG_TAPS, 0));
        check_eq("R4", "centre value", big_log[191], coef_tb(0, BIG_TAPS, 191));
        check_eq("R4", "centre repeats", big_log[192], big_log[191]);
        for (int j = 1; j < 6; j++) begin
            check_eq("R4", "mirrored tail", big_log[192+j], big_log[191-j]);
        end
        check_eq("R4", "last coefficient", big_log[383], coef_tb(0, BIG_TAPS, 0));
        check_eq("R4", "after impulse leaves", big_log[384], 0);
        for (int k = 0; k < SML_TAPS; k++) begin
            check_eq("R4", "small impulse", sml_log[k], coef_tb(1, SML_TAPS, k));
        end
    endtask

    task automatic test_step();
        longint total = 0;
        cur_scn = "step";
        for (int k = 0; k < BIG_TAPS; k++) total += coef_tb(0, BIG_TAPS, k);
        apply_reset();
        for (int i = 0; i < 400; i++) push(1, 1'b1);
        idle(BIG_LAT + 4);
        check_eq("R5", "big settles at first full output", big_log[BIG_TAPS-1], total);
        check_eq("R5", "big stays settled", big_log[399], total);
        check_eq("R5", "small folded settles at 22", sml_log[n_sml-1], 22);
        check_eq("R5", "small plain settles at 22", flt_log[n_flt-1], 22);
        check_eq("R5", "small settled at output 7", sml_log[SML_TAPS-1], 22);
    endtask

    task automatic test_extreme();
        longint hi = 0;
        longint lo = 0;
        cur_scn = "extreme";
        apply_reset();
        for (int j = 0; j < BIG_TAPS; j++) begin
            longint c = coef_tb(0, BIG_TAPS, BIG_TAPS - 1 - j);
            longint v = (c >= 0) ? 32767 : -32768;
            hi += c * v;
            push(v, 1'b1);
        end
        for (int j = 0; j < BIG_TAPS; j++) begin
            longint c = coef_tb(0, BIG_TAPS, BIG_TAPS - 1 - j);
            longint v = (c >= 0) ? -32768 : 32767;
            lo += c * v;
            push(v, 1'b1);
        end
        idle(BIG_LAT + 4);
        check_eq("R3", "largest positive sum", big_log[BIG_TAPS-1], hi);
        check_eq("R3", "largest negative sum", big_log[2*BIG_TAPS-1], lo);
    endtask

    task automatic test_latency();
        int edges = 1;
        int lat_big = -1;
        int lat_sml = -1;
        int lat_flt = -1;
        cur_scn = "latency";
        apply_reset();
        @(negedge clk);
        in_sample = 16'sd5;
        in_valid = 1'b1;
        hist[hist_len] = 5;
        hist_len++;
        @(negedge clk);
        in_valid = 1'b0;
        while (edges < 40) begin
            if (big_ov && lat_big < 0) lat_big = edges;
            if (sml_ov && lat_sml < 0) lat_sml = edges;
            if (flt_ov && lat_flt < 0) lat_flt = edges;
            @(negedge clk);
            edges++;
        end
        check_eq("R6", "big latency", lat_big, BIG_LAT);
        check_eq("R6", "small folded latency", lat_sml, SML_LAT);
        check_eq("R6", "small plain latency", lat_flt, FLT_LAT);
    endtask

    task automatic test_gaps();
        logic [15:0] lfsr = 16'hACE1;
        longint held;
        cur_scn = "gaps";
        apply_reset();
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(longint'($signed(lfsr)), lfsr[0] | lfsr[3]);
        end
        idle(BIG_LAT + 4);
        check_eq("R7", "big outputs equal accepted samples", n_big, hist_len);
        check_eq("R7", "small outputs equal accepted samples", n_sml, hist_len);
        check_eq("R9", "folded and plain agree", sml_log[n_sml-1], flt_log[n_flt-1]);
        held = longint'(sml_od);
        idle(6);
        check_eq("R7", "small data held while idle", longint'(sml_od), held);
        check_eq("R7", "small valid low while idle", longint'(sml_ov), 0);
    endtask

    task automatic test_midreset();
        cur_scn = "midreset";
        apply_reset();
        for (int i = 0; i < 20; i++) push(1000 + i, 1'b1);
        idle(BIG_LAT + 4);
        apply_reset();
        push(1, 1'b1);
        for (int i = 0; i < 10; i++) push(0, 1'b1);
        idle(BIG_LAT + 4);
        check_eq("R8", "big starts from rest", big_log[0], coef_tb(0, BIG_TAPS, 0));
        for (int k = 0; k < SML_TAPS; k++) begin
            check_eq("R8", "small starts from rest", sml_log[k], coef_tb(1, SML_TAPS, k));
        end
        check_eq("R2", "small set symmetric", sml_log[3], sml_log[4]);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_impulse();
        test_step();
        test_extreme();
        test_latency();
        test_gaps();
        test_midreset();
        finish_run();
    end

endmodule